// File: doc/BRIEF.md
# SONET frame byte position timer

This block follows the byte stream of an STS-1 or STS-3/STM-1 frame and reports where the current byte sits. It reports the row (0 to 8) and the column (0 to 269 or 0 to 89). It locks to the frame through a one-cycle sync pulse. In STS-3 mode the pulse is taken to mark column 10. In STS-1 mode it is taken to mark column 4.

From that position the block decodes strobes for the two pointer bytes of each interleaved tributary, H1 and H2. All of them fall in the fourth row, row index 3. Each strobe also has a copy delayed by four byte times. Downstream logic that runs the data through a four-stage pipeline can use these copies to act on the pointer bytes as they leave that pipeline. The mode input selects the frame size and the strobe columns.

Top module: `frame_pos_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, row and column are 0, the row-3 level is low and all twelve strobes are low.
- R2: A sync pulse sampled at a clock edge sets the column to 10 in STS-3 mode (mode input 1) or 4 in STS-1 mode (mode input 0), and sets the row to 0 in the next cycle.
- R3: Without sync, the column counts up by one per clock. After column 269 (STS-3) or column 89 (STS-1) it returns to 0. A column above the STS-1 limit, left behind by a switch from STS-3 to STS-1 mode, returns to 0 on the next clock.
- R4: The row advances by one exactly when the column returns to 0, and it goes from 8 back to 0. It holds otherwise.
- R5: The row-3 output is a registered level that is high exactly while the row equals 3.
- R6: In STS-3 mode, strobe bit k of the H1 group (k = 0, 1, 2) is high only in row 3, column k. Strobe bit k of the H2 group is high only in row 3, column 3+k.
- R7: In STS-1 mode, H1 bit 0 is high in row 3, column 0, and H2 bit 0 is high in row 3, column 1. Bits 1 and 2 of both groups stay low.
- R8: Each delayed strobe output equals the matching strobe four clock cycles earlier. Before four cycles have passed since reset, it is low.
- R9: At most one of the six strobes is high in any cycle, and at most one of the six delayed strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame pulse, one byte wide |
| sts3_mode_i | input | 1 | 1 selects STS-3/STM-1, 0 selects STS-1 |
| row_o | output | 4 | Current row, 0 to 8 |
| col_o | output | 9 | Current column |
| row3_o | output | 1 | High for the whole of row 3 |
| h1_o | output | 3 | H1 strobe, one bit per tributary |
| h2_o | output | 3 | H2 strobe, one bit per tributary |
| h1_dly_o | output | 3 | H1 strobes delayed four cycles |
| h2_dly_o | output | 3 | H2 strobes delayed four cycles |

## Verification
The checker follows the counters on every cycle. It checks the preset on sync, the one-step column advance, the wrap in both modes, the row advance and its wrap, the row-3 level, the quiet upper strobes in STS-1 mode, the four-cycle delay and the one-hot strobes. Only the bench scenarios can show that each strobe lands on its exact column across complete frames in both modes. The same goes for a mode switch in mid-row and a sync arriving in the middle of a frame.

// File: rtl/frame_pos_pkg.sv
package frame_pos_pkg;
  localparam int unsigned FP_ROWS      = 9;
  localparam int unsigned FP_COLS_WIDE = 270;
  localparam int unsigned FP_COLS_NARR = 90;
  localparam int unsigned FP_SYNC_WIDE = 10;
  localparam int unsigned FP_SYNC_NARR = 4;
  localparam int unsigned FP_PTR_ROW   = 3;
  localparam int unsigned FP_TRIBS     = 3;
  localparam int unsigned FP_DLY       = 4;

  function automatic int unsigned fp_clog2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction
endpackage

// File: rtl/fpt_pos_counter.sv
module fpt_pos_counter #(
  parameter int unsigned ROWS      = 9,
  parameter int unsigned COLS_WIDE = 270,
  parameter int unsigned COLS_NARR = 90,
  parameter int unsigned SYNC_WIDE = 10,
  parameter int unsigned SYNC_NARR = 4,
  parameter int unsigned PTR_ROW   = 3,
  parameter int unsigned ROW_W     = 4,
  parameter int unsigned COL_W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             wide_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             ptr_row_o
);
  localparam logic [COL_W-1:0] LAST_WIDE = COL_W'(COLS_WIDE - 1);
  localparam logic [COL_W-1:0] LAST_NARR = COL_W'(COLS_NARR - 1);
  localparam logic [COL_W-1:0] PRE_WIDE  = COL_W'(SYNC_WIDE);
  localparam logic [COL_W-1:0] PRE_NARR  = COL_W'(SYNC_NARR);
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_PTR   = ROW_W'(PTR_ROW);

  logic [COL_W-1:0] col_q, col_d, col_last;
  logic [ROW_W-1:0] row_q, row_d;
  logic             ptr_q;
  logic             row_end;

  assign col_last = wide_i ? LAST_WIDE : LAST_NARR;
  // >= so a column stranded past the narrow limit after a mode change wraps
  assign row_end  = (col_q >= col_last);

  always_comb begin
    col_d = col_q + 1'b1;
    row_d = row_q;
    if (sync_i) begin
      col_d = wide_i ? PRE_WIDE : PRE_NARR;
      row_d = '0;
    end else if (row_end) begin
      col_d = '0;
      row_d = (row_q >= ROW_LAST) ? '0 : row_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      ptr_q <= 1'b0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
      ptr_q <= (row_d == ROW_PTR);
    end
  end

  assign row_o     = row_q;
  assign col_o     = col_q;
  assign ptr_row_o = ptr_q;
endmodule

// File: rtl/fpt_ptr_decode.sv
module fpt_ptr_decode #(
  parameter int unsigned COL_W     = 9,
  parameter int unsigned TRIBS     = 3,
  parameter int unsigned H1_NARROW = 0,
  parameter int unsigned H2_NARROW = 1
) (
  input  logic [COL_W-1:0] col_i,
  input  logic             ptr_row_i,
  input  logic             wide_i,
  output logic [TRIBS-1:0] h1_o,
  output logic [TRIBS-1:0] h2_o
);
  for (genvar k = 0; k < TRIBS; k++) begin : g_trib
    localparam logic [COL_W-1:0] H1_WIDE = COL_W'(k);
    localparam logic [COL_W-1:0] H2_WIDE = COL_W'(TRIBS + k);
    if (k == 0) begin : g_mux
      logic [COL_W-1:0] h1_col, h2_col;
      assign h1_col  = wide_i ? H1_WIDE : COL_W'(H1_NARROW);
      assign h2_col  = wide_i ? H2_WIDE : COL_W'(H2_NARROW);
      assign h1_o[k] = ptr_row_i && (col_i == h1_col);
      assign h2_o[k] = ptr_row_i && (col_i == h2_col);
    end else begin : g_wide_only
      assign h1_o[k] = ptr_row_i && wide_i && (col_i == H1_WIDE);
      assign h2_o[k] = ptr_row_i && wide_i && (col_i == H2_WIDE);
    end
  end
endmodule

// File: rtl/fpt_strobe_delay.sv
module fpt_strobe_delay #(
  parameter int unsigned W     = 6,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] stage_q;

  if (DEPTH == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[DEPTH-2:0], d_i};
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/frame_pos_timer.sv
module frame_pos_timer
  import frame_pos_pkg::*;
#(
  parameter int unsigned ROWS      = FP_ROWS,
  parameter int unsigned COLS_WIDE = FP_COLS_WIDE,
  parameter int unsigned COLS_NARR = FP_COLS_NARR,
  parameter int unsigned SYNC_WIDE = FP_SYNC_WIDE,
  parameter int unsigned SYNC_NARR = FP_SYNC_NARR,
  parameter int unsigned PTR_ROW   = FP_PTR_ROW,
  parameter int unsigned TRIBS     = FP_TRIBS,
  parameter int unsigned DLY       = FP_DLY,
  localparam int unsigned ROW_W    = fp_clog2(ROWS),
  localparam int unsigned COL_W    = fp_clog2(COLS_WIDE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             sts3_mode_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             row3_o,
  output logic [TRIBS-1:0] h1_o,
  output logic [TRIBS-1:0] h2_o,
  output logic [TRIBS-1:0] h1_dly_o,
  output logic [TRIBS-1:0] h2_dly_o
);
  logic [COL_W-1:0]   col;
  logic               ptr_row;
  logic [TRIBS-1:0]   h1, h2;
  logic [2*TRIBS-1:0] dly;

  fpt_pos_counter #(
    .ROWS(ROWS), .COLS_WIDE(COLS_WIDE), .COLS_NARR(COLS_NARR),
    .SYNC_WIDE(SYNC_WIDE), .SYNC_NARR(SYNC_NARR), .PTR_ROW(PTR_ROW),
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) i_pos_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .wide_i(sts3_mode_i),
    .row_o(row_o), .col_o(col), .ptr_row_o(ptr_row)
  );

  fpt_ptr_decode #(
    .COL_W(COL_W), .TRIBS(TRIBS)
  ) i_ptr_decode (
    .col_i(col), .ptr_row_i(ptr_row), .wide_i(sts3_mode_i),
    .h1_o(h1), .h2_o(h2)
  );

  fpt_strobe_delay #(
    .W(2*TRIBS), .DEPTH(DLY)
  ) i_strobe_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({h2, h1}), .q_o(dly)
  );

  assign col_o    = col;
  assign row3_o   = ptr_row;
  assign h1_o     = h1;
  assign h2_o     = h2;
  assign h1_dly_o = dly[TRIBS-1:0];
  assign h2_dly_o = dly[2*TRIBS-1:TRIBS];
endmodule

// File: rtl/fpt_checker.sv
module fpt_checker #(
  parameter int unsigned ROWS      = 9,
  parameter int unsigned COLS_WIDE = 270,
  parameter int unsigned COLS_NARR = 90,
  parameter int unsigned SYNC_WIDE = 10,
  parameter int unsigned SYNC_NARR = 4,
  parameter int unsigned PTR_ROW   = 3,
  parameter int unsigned TRIBS     = 3,
  parameter int unsigned DLY       = 4,
  parameter int unsigned ROW_W     = 4,
  parameter int unsigned COL_W     = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             sts3_mode_i,
  input logic [ROW_W-1:0] row_o,
  input logic [COL_W-1:0] col_o,
  input logic             row3_o,
  input logic [TRIBS-1:0] h1_o,
  input logic [TRIBS-1:0] h2_o,
  input logic [TRIBS-1:0] h1_dly_o,
  input logic [TRIBS-1:0] h2_dly_o
);
  localparam logic [COL_W-1:0] LAST_WIDE = COL_W'(COLS_WIDE - 1);
  localparam logic [COL_W-1:0] LAST_NARR = COL_W'(COLS_NARR - 1);
  localparam logic [COL_W-1:0] PRE_WIDE  = COL_W'(SYNC_WIDE);
  localparam logic [COL_W-1:0] PRE_NARR  = COL_W'(SYNC_NARR);
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_PTR   = ROW_W'(PTR_ROW);

  logic [COL_W-1:0] lim;
  assign lim = sts3_mode_i ? LAST_WIDE : LAST_NARR;

  // independent shadow of the strobes for the delay check
  logic [DLY-1:0][2*TRIBS-1:0] shadow_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else begin
      for (int s = DLY - 1; s > 0; s--) shadow_q[s] <= shadow_q[s-1];
      shadow_q[0] <= {h2_o, h1_o};
    end
  end

  assert_sync_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (row_o == '0) && (col_o == ($past(sts3_mode_i) ? PRE_WIDE : PRE_NARR)));

  assert_col_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && col_o < lim) |=> col_o == $past(col_o) + 1'b1);

  assert_col_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && col_o >= lim) |=> col_o == '0);

  assert_row_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && col_o < lim) |=> $stable(row_o));

  assert_row_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && col_o >= lim && row_o == ROW_LAST) |=> row_o == '0);

  assert_row_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o <= ROW_LAST);

  assert_row3_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row3_o == (row_o == ROW_PTR));

  assert_strobe_row_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{h1_o, h2_o}) |-> row3_o);

  assert_narrow_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts3_mode_i |-> ((h1_o >> 1) == '0) && ((h2_o >> 1) == '0));

  assert_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {h2_dly_o, h1_dly_o} == shadow_q[DLY-1]);

  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({h1_o, h2_o}) && $onehot0({h1_dly_o, h2_dly_o}));
endmodule

bind frame_pos_timer fpt_checker #(
  .ROWS(ROWS), .COLS_WIDE(COLS_WIDE), .COLS_NARR(COLS_NARR),
  .SYNC_WIDE(SYNC_WIDE), .SYNC_NARR(SYNC_NARR), .PTR_ROW(PTR_ROW),
  .TRIBS(TRIBS), .DLY(DLY), .ROW_W(ROW_W), .COL_W(COL_W)
) i_fpt_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .sts3_mode_i(sts3_mode_i),
  .row_o(row_o), .col_o(col_o), .row3_o(row3_o), .h1_o(h1_o), .h2_o(h2_o),
  .h1_dly_o(h1_dly_o), .h2_dly_o(h2_dly_o)
);

// File: tb/test_frame_pos_timer.sv
module test_frame_pos_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic       sts3_mode_i = 1'b1;
  logic [3:0] row_o;
  logic [8:0] col_o;
  logic       row3_o;
  logic [2:0] h1_o, h2_o, h1_dly_o, h2_dly_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  int exp_row, exp_col;
  logic [5:0] hist [DLY];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  frame_pos_timer i_frame_pos_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .sts3_mode_i(sts3_mode_i),
    .row_o(row_o), .col_o(col_o), .row3_o(row3_o), .h1_o(h1_o), .h2_o(h2_o),
    .h1_dly_o(h1_dly_o), .h2_dly_o(h2_dly_o)
  );

  function automatic logic [5:0] exp_strobes(int r, int c, logic wide);
    logic [2:0] a, b;
    for (int k = 0; k < 3; k++) begin
      if (wide) begin
        a[k] = (r == 3) && (c == k);
        b[k] = (r == 3) && (c == 3 + k);
      end else begin
        a[k] = (r == 3) && (k == 0) && (c == 0);
        b[k] = (r == 3) && (k == 0) && (c == 1);
      end
    end
    return {b, a};
  endfunction

  task automatic check(string req, int act, int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_fails++;
      if (n_fails < 30) $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp_v);
    end
  endtask

  task automatic compare(string pos_req);
    logic [5:0] s;
    s = exp_strobes(exp_row, exp_col, sts3_mode_i);
    check(pos_req, int'(col_o), exp_col);
    check(pos_req, int'(row_o), exp_row);
    check("R5", int'(row3_o), int'(exp_row == 3));
    check(sts3_mode_i ? "R6" : "R7", int'({h2_o, h1_o}), int'(s));
    check("R8", int'({h2_dly_o, h1_dly_o}), int'(hist[DLY-1]));
    check("R9", int'($countones({h1_o, h2_o}) <= 1 && $countones({h1_dly_o, h2_dly_o}) <= 1), 1);
  endtask

  // called at a negedge: drive, advance model across next posedge, compare
  task automatic step(logic sync, logic wide, string pos_req);
    int ncol, nrow, last;
    sync_i = sync;
    sts3_mode_i = wide;
    last = wide ? 269 : 89;
    for (int i = DLY - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = exp_strobes(exp_row, exp_col, wide);
    nrow = exp_row;
    if (sync) begin
      ncol = wide ? 10 : 4;
      nrow = 0;
    end else if (exp_col >= last) begin
      ncol = 0;
      nrow = (exp_row == 8) ? 0 : exp_row + 1;
    end else begin
      ncol = exp_col + 1;
    end
    @(negedge clk_i);
    exp_col = ncol;
    exp_row = nrow;
    compare(pos_req);
  endtask

  initial begin
    for (int i = 0; i < DLY; i++) hist[i] = '0;
    exp_row = 0;
    exp_col = 0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", int'(col_o), 0);
    check("R1", int'(row_o), 0);
    check("R1", int'(row3_o), 0);
    check("R1", int'({h2_o, h1_o, h2_dly_o, h1_dly_o}), 0);
    rst_ni = 1'b1;
    step(1'b0, 1'b1, "R1");

    // R2/R6: sync in STS-3, then two full frames (covers R3/R4 wraps)
    step(1'b1, 1'b1, "R2");
    for (int n = 0; n < 2 * 9 * 270; n++) step(1'b0, 1'b1, "R3");

    // R2/R7: sync in STS-1, then two full frames
    step(1'b1, 1'b0, "R2");
    for (int n = 0; n < 2 * 9 * 90; n++) step(1'b0, 1'b0, "R4");

    // R3: switch to STS-1 while column is far past 89
    step(1'b1, 1'b1, "R2");
    while (exp_col != 200) step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, "R3");
    for (int n = 0; n < 9 * 90; n++) step(1'b0, 1'b0, "R4");

    // R2: mid-frame sync back into STS-3
    while (!(exp_row == 5 && exp_col == 50)) step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, "R2");
    for (int n = 0; n < 9 * 270; n++) step(1'b0, 1'b1, "R6");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule